// File: doc/BRIEF.md
# I2C Motor-Bridge Register Target

This block is an I2C target that gives a host access to two byte-wide registers through a sub-address pointer. A transfer opens with the target's 7-bit address. A write then carries a sub-address byte and one or more data bytes. A read first sets the pointer with a write of the sub-address, then uses a repeated START with the read bit and streams bytes back. The pointer moves forward after every data byte, in both directions.

The control register drives a 6-bit voltage-setting code and two bridge-state bits, which leave the block as plain outputs. The fault register collects four fault level inputs (current limit, over-temperature, undervoltage, overcurrent) into sticky status bits. The host clears them by writing the register with its top bit set.

SCL and SDA are sampled with a fast system clock through synchronizers. SDA is driven as an open-drain enable.

Top module: `bridgeCtrlTarget`

## Requirements
- R1: The target acknowledges only the address {1,1,0, addrSel[3:0]}, with the read/write bit as the eighth bit (1 = read). For any other address it leaves SDA released in the acknowledge slot and ignores the rest of the transfer.
- R2: In a write, the address, the sub-address byte and every data byte are each acknowledged by pulling SDA low during the ninth clock.
- R3: Sub-address 0x00 is the control register, reset 0x00. Bits 7:2 drive vSet[5:0], bit 1 drives bridgeIn2 and bit 0 drives bridgeIn1.
- R4: The control outputs change only after the ninth (acknowledge) clock of a data byte has ended. They hold their old value throughout the byte and its acknowledge clock.
- R5: Sub-address 0x01 is the fault register, reset 0x00. Its layout is bit 4 current limit (faultIn[3]), bit 3 over-temperature (faultIn[2]), bit 2 undervoltage (faultIn[1]), bit 1 overcurrent (faultIn[0]), and bit 0 the OR of bits 4:1. Each status bit sets when its input is high and stays set. Bits 7:5 always read 0.
- R6: A write of the fault register with bit 7 set clears the latched status. A fault input that is still high sets its bit again on the next cycle. A write with bit 7 clear changes nothing.
- R7: A read uses a repeated START after the sub-address write. Bytes are sent MSB first. The pointer advances after every data byte written or read, and wraps from 0x01 back to 0x00.
- R8: Data written to sub-addresses above 0x01 is acknowledged and discarded. Reads from those sub-addresses return 0x00.
- R9: When the host NACKs a read byte, the target releases SDA and waits for the next START or STOP.
- R10: After reset SDA is released and all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled SCL line |
| sdaIn | input | 1 | Sampled SDA line |
| sdaOe | output | 1 | 1 pulls SDA low |
| addrSel | input | 4 | Low address bits of the target |
| faultIn | input | 4 | Fault levels: [3] current limit, [2] over-temperature, [1] undervoltage, [0] overcurrent |
| vSet | output | 6 | Voltage-setting code |
| bridgeIn2 | output | 1 | Bridge state bit 2 |
| bridgeIn1 | output | 1 | Bridge state bit 1 |

## Verification
Single-byte and multi-byte writes with distinct bit patterns (0xB6, 0x57) show that each field lands on the correct output. A write that starts at the fault register and runs on into the control register shows the pointer wrap. Three-byte reads, a foreign address, and an out-of-range sub-address separate pointer advance from address matching and from the discard path. Fault pulses, a clear while an input is still high, and a write without the clear bit separate sticky set, clear, and re-set. A snapshot taken inside the acknowledge clock shows that the outputs do not move before the byte is complete.

// File: rtl/bridgeCtrlPkg.sv
package bridgeCtrlPkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 4;
  localparam int FAULT_N = 4;
  localparam int ADDR_W  = 7;
  localparam logic [ADDR_W-SEL_W-1:0] ADDR_PREFIX = 3'b110;
  localparam logic [BYTE_W-1:0] SUB_CTRL  = 8'h00;
  localparam logic [BYTE_W-1:0] SUB_FAULT = 8'h01;
  localparam int CLEAR_BIT = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_SUB, S_SUB_ACK,
    S_WR_DATA, S_WR_ACK, S_RD_DATA, S_RD_ACK
  } busState_t;

  typedef struct packed {
    logic              loadPtr;
    logic              commitWrite;
    logic              advancePtr;
    logic [BYTE_W-1:0] rxByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/lineSync.sv
module lineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '1;
        else       pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/busCtrl.sv
module busCtrl
  import bridgeCtrlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [SEL_W-1:0]  addrSel,
  input  logic [BYTE_W-1:0] rdByte,
  output ctrlStrobes_t      strobes,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftIn, txShift;
  logic readMode, hostNack, byteDone;
  logic [ADDR_W-1:0] ownAddr;

  lineSync #(.STAGES(SYNC_STAGES)) u_sclSync (.clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  lineSync #(.STAGES(SYNC_STAGES)) u_sdaSync (.clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign ownAddr   = {ADDR_PREFIX, addrSel};
  assign byteDone  = (bitCnt == CNT_W'(BYTE_W));

  // Strobes to the datapath fire on the falling SCL edge that ends a phase
  always_comb begin
    strobes        = '0;
    strobes.rxByte = shiftIn;
    if (sclFall) begin
      case (state)
        S_SUB_ACK: strobes.loadPtr = 1'b1;
        S_WR_ACK: begin
          strobes.commitWrite = 1'b1;
          strobes.advancePtr  = 1'b1;
        end
        S_RD_DATA: strobes.advancePtr = byteDone;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shiftIn  <= '0;
      txShift  <= '0;
      readMode <= 1'b0;
      hostNack <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (stopSeen) begin
      state <= S_IDLE;
      sdaOe <= 1'b0;
    end else if (startSeen) begin
      state  <= S_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (sclRise) begin
      case (state)
        S_ADDR, S_SUB, S_WR_DATA:
          if (!byteDone) begin
            shiftIn <= {shiftIn[BYTE_W-2:0], sdaS};
            bitCnt  <= bitCnt + 1'b1;
          end
        S_RD_DATA: if (!byteDone) bitCnt <= bitCnt + 1'b1;
        S_RD_ACK:  hostNack <= sdaS;
        default: ;
      endcase
    end else if (sclFall) begin
      case (state)
        S_ADDR:
          if (byteDone) begin
            if (shiftIn[BYTE_W-1:1] == ownAddr) begin
              sdaOe    <= 1'b1;
              readMode <= shiftIn[0];
              state    <= S_ADDR_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
        S_ADDR_ACK: begin
          bitCnt <= '0;
          if (readMode) begin
            state   <= S_RD_DATA;
            txShift <= rdByte;
            sdaOe   <= ~rdByte[BYTE_W-1];
          end else begin
            state <= S_SUB;
            sdaOe <= 1'b0;
          end
        end
        S_SUB:
          if (byteDone) begin
            sdaOe <= 1'b1;
            state <= S_SUB_ACK;
          end
        S_SUB_ACK, S_WR_ACK: begin
          sdaOe  <= 1'b0;
          bitCnt <= '0;
          state  <= S_WR_DATA;
        end
        S_WR_DATA:
          if (byteDone) begin
            sdaOe <= 1'b1;
            state <= S_WR_ACK;
          end
        S_RD_DATA:
          if (byteDone) begin
            sdaOe <= 1'b0;
            state <= S_RD_ACK;
          end else begin
            txShift <= {txShift[BYTE_W-2:0], 1'b0};
            sdaOe   <= ~txShift[BYTE_W-2];
          end
        S_RD_ACK:
          if (hostNack) begin
            state <= S_IDLE;
          end else begin
            state   <= S_RD_DATA;
            bitCnt  <= '0;
            txShift <= rdByte;
            sdaOe   <= ~rdByte[BYTE_W-1];
          end
        default: ;
      endcase
    end
  end

  // R1: an address acknowledge only ever follows a matching address byte
  p_ack_own_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && state == S_ADDR_ACK) |-> ($past(shiftIn[BYTE_W-1:1]) == ownAddr));

  // R9: SDA is pulled only in acknowledge or transmit phases
  p_oe_drive_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state inside {S_ADDR_ACK, S_SUB_ACK, S_WR_ACK, S_RD_DATA}));
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import bridgeCtrlPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [FAULT_N-1:0] faultIn,
  output logic [BYTE_W-1:0]  rdByte,
  output logic [BYTE_W-1:0]  ctrlWord
);
  localparam int PAD_W = BYTE_W - FAULT_N - 1;

  logic [BYTE_W-1:0]  ptr;
  logic [FAULT_N-1:0] faultLatch;
  logic [BYTE_W-1:0]  faultWord;
  logic clearReq;

  assign clearReq  = strobes.commitWrite && (ptr == SUB_FAULT) && strobes.rxByte[CLEAR_BIT];
  assign faultWord = {{PAD_W{1'b0}}, faultLatch, |faultLatch};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= SUB_CTRL;
    end else if (strobes.loadPtr) begin
      ptr <= strobes.rxByte;
    end else if (strobes.advancePtr) begin
      ptr <= (ptr == SUB_FAULT) ? SUB_CTRL : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (strobes.commitWrite && ptr == SUB_CTRL) begin
      ctrlWord <= strobes.rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         faultLatch <= '0;
    else if (clearReq) faultLatch <= '0;
    else               faultLatch <= faultLatch | faultIn;
  end

  always_comb begin
    case (ptr)
      SUB_CTRL:  rdByte = ctrlWord;
      SUB_FAULT: rdByte = faultWord;
      default:   rdByte = '0;
    endcase
  end

  // R4: control word moves only on a completed, acknowledged byte
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitWrite |=> $stable(ctrlWord));

  // R5: a status bit never drops without a clear
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> ((faultLatch & $past(faultLatch)) == $past(faultLatch)));

  // R5: an asserted fault input is captured on the next cycle
  p_fault_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> ((faultLatch & $past(faultIn)) == $past(faultIn)));
endmodule

// File: rtl/bridgeCtrlTarget.sv
module bridgeCtrlTarget
  import bridgeCtrlPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [SEL_W-1:0]   addrSel,
  input  logic [FAULT_N-1:0] faultIn,
  output logic [5:0]         vSet,
  output logic               bridgeIn2,
  output logic               bridgeIn1
);
  ctrlStrobes_t strobes;
  logic [BYTE_W-1:0] rdByte, ctrlWord;

  busCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_busCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdByte(rdByte), .strobes(strobes), .sdaOe(sdaOe)
  );

  regDatapath u_regDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultIn(faultIn),
    .rdByte(rdByte), .ctrlWord(ctrlWord)
  );

  assign vSet      = ctrlWord[7:2];
  assign bridgeIn2 = ctrlWord[1];
  assign bridgeIn1 = ctrlWord[0];
endmodule

// File: tb/test_bridgeCtrlTarget.sv
module test_bridgeCtrlTarget;
  localparam int H = 20;
  localparam logic [7:0] ADDR_W_BYTE = 8'hD4;
  localparam logic [7:0] ADDR_R_BYTE = 8'hD5;
  localparam logic [7:0] FOREIGN_W   = 8'hD6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [3:0] addrSel = 4'b1010;
  logic [3:0] faultIn = 4'b0000;
  logic [5:0] vSet;
  logic bridgeIn2, bridgeIn1;
  logic [7:0] midSnap;

  int total = 0;
  int bad = 0;

  typedef struct {
    string      req;
    logic [7:0] val;
  } expItem_t;
  expItem_t   expQ[$];
  logic [7:0] actQ[$];

  always #2 clk = ~clk;

  assign sdaLine = sdaHost & ~sdaOe;

  bridgeCtrlTarget i_bridgeCtrlTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .faultIn(faultIn), .vSet(vSet),
    .bridgeIn2(bridgeIn2), .bridgeIn1(bridgeIn1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (H) @(negedge clk);
  endtask

  task automatic hostStart();
    sdaHost = 1'b1; sclHost = 1'b1; halfWait();
    sdaHost = 1'b0; halfWait();
    sclHost = 1'b0; halfWait();
  endtask

  task automatic hostRestart();
    sdaHost = 1'b1; halfWait();
    sclHost = 1'b1; halfWait();
    sdaHost = 1'b0; halfWait();
    sclHost = 1'b0; halfWait();
  endtask

  task automatic hostStop();
    sdaHost = 1'b0; halfWait();
    sclHost = 1'b1; halfWait();
    sdaHost = 1'b1; halfWait();
  endtask

  task automatic sendBit(input logic b);
    sdaHost = b; halfWait();
    sclHost = 1'b1; halfWait();
    sclHost = 1'b0;
  endtask

  task automatic recvBit(output logic b);
    sdaHost = 1'b1; halfWait();
    sclHost = 1'b1;
    repeat (H/2) @(negedge clk);
    b = sdaLine;
    midSnap = {vSet, bridgeIn2, bridgeIn1};
    repeat (H/2) @(negedge clk);
    sclHost = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic readByte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(last);
  endtask

  task automatic expectRd(input string req, input logic [7:0] v);
    expItem_t it;
    it.req = req;
    it.val = v;
    expQ.push_back(it);
  endtask

  task automatic readSeq(input string req, input logic [7:0] sub, input int n);
    logic ack;
    logic [7:0] v;
    hostStart();
    writeByte(ADDR_W_BYTE, ack); check({req, " addr ack"}, ack, 1);
    writeByte(sub, ack);         check({req, " sub ack"}, ack, 1);
    hostRestart();
    writeByte(ADDR_R_BYTE, ack); check({req, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i == n - 1, v);
      actQ.push_back(v);
    end
    hostStop();
    repeat (8) @(negedge clk);
    check({req, " R9 SDA released after NACK"}, sdaOe, 0);
  endtask

  task automatic writeOne(input string req, input logic [7:0] sub, input logic [7:0] d);
    logic ack;
    hostStart();
    writeByte(ADDR_W_BYTE, ack); check({req, " R2 addr ack"}, ack, 1);
    writeByte(sub, ack);         check({req, " R2 sub ack"}, ack, 1);
    writeByte(d, ack);           check({req, " R2 data ack"}, ack, 1);
    hostStop();
    repeat (8) @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      logic [7:0] a;
      expItem_t e;
      wait (actQ.size() != 0);
      a = actQ.pop_front();
      if (expQ.size() == 0) begin
        check("scoreboard unexpected read", a, 32'hFFFF);
      end else begin
        e = expQ.pop_front();
        check(e.req, a, e.val);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 sdaOe", sdaOe, 0);
    check("R10 outputs", {vSet, bridgeIn2, bridgeIn1}, 8'h00);

    // R3 R5 reset values of both registers
    expectRd("R3 control reset", 8'h00);
    expectRd("R5 fault reset", 8'h00);
    readSeq("R3R5 reset read", 8'h00, 2);

    // R2 R3 R4 single write to control
    writeOne("R3 write", 8'h00, 8'hB6);
    check("R4 no change inside ack clock", midSnap, 8'h00);
    check("R3 vSet", vSet, 6'h2D);
    check("R3 bridgeIn2", bridgeIn2, 1);
    check("R3 bridgeIn1", bridgeIn1, 0);

    // R1 foreign address ignored
    hostStart();
    writeByte(FOREIGN_W, ack); check("R1 foreign address NACK", ack, 0);
    writeByte(8'h00, ack);
    writeByte(8'h00, ack);
    hostStop();
    repeat (8) @(negedge clk);
    check("R1 foreign write ignored", {vSet, bridgeIn2, bridgeIn1}, 8'hB6);

    // R7 multi-byte write: fault (no clear) then wrap to control
    hostStart();
    writeByte(ADDR_W_BYTE, ack); check("R2 addr ack multi", ack, 1);
    writeByte(8'h01, ack);       check("R2 sub ack multi", ack, 1);
    writeByte(8'h00, ack);       check("R2 data ack fault", ack, 1);
    writeByte(8'h57, ack);       check("R7 data ack after wrap", ack, 1);
    check("R4 old value during ack clock", midSnap, 8'hB6);
    hostStop();
    repeat (8) @(negedge clk);
    check("R7 wrap wrote control", {vSet, bridgeIn2, bridgeIn1}, 8'h57);

    // R7 three-byte read with wrap
    expectRd("R7 read byte0", 8'h57);
    expectRd("R7 read byte1", 8'h00);
    expectRd("R7 read byte2 wrap", 8'h57);
    readSeq("R7 burst", 8'h00, 3);

    // R5 sticky faults
    @(negedge clk); faultIn = 4'b0100;
    repeat (3) @(negedge clk); faultIn = 4'b0000;
    expectRd("R5 over-temperature latched", 8'h09);
    readSeq("R5 ots", 8'h01, 1);
    @(negedge clk); faultIn = 4'b0001;
    @(negedge clk); faultIn = 4'b0000;
    expectRd("R5 overcurrent added", 8'h0B);
    readSeq("R5 ocp", 8'h01, 1);

    // R6 write without clear bit changes nothing
    writeOne("R6 no clear", 8'h01, 8'h7F);
    expectRd("R6 write without bit7 ignored", 8'h0B);
    readSeq("R6 noclr", 8'h01, 1);

    // R6 clear with undervoltage still high
    faultIn = 4'b0010;
    writeOne("R6 clear held", 8'h01, 8'h80);
    faultIn = 4'b0000;
    expectRd("R6 held input sets again", 8'h05);
    readSeq("R6 held", 8'h01, 1);
    writeOne("R6 clear idle", 8'h01, 8'h80);
    expectRd("R6 cleared", 8'h00);
    readSeq("R6 idle", 8'h01, 1);

    // R5 current limit maps to bit 4
    @(negedge clk); faultIn = 4'b1000;
    @(negedge clk); faultIn = 4'b0000;
    expectRd("R5 current limit bit4", 8'h11);
    readSeq("R5 ilimit", 8'h01, 1);

    // R8 out-of-range sub-address
    writeOne("R8 discard", 8'h05, 8'hFF);
    check("R8 control untouched", {vSet, bridgeIn2, bridgeIn1}, 8'h57);
    expectRd("R8 out-of-range reads zero", 8'h00);
    readSeq("R8 read", 8'h05, 1);

    wait (actQ.size() == 0);
    repeat (4) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule